// File: doc/BRIEF.md
# Dual-Channel Crosspoint Enable and Powerdown Controller

This block models the control plane of a two-channel crosspoint. Each channel has two switch-side data inputs, one line-side input, two switch-side outputs and one line-side output. A per-channel select picks which switch input feeds the line output. Each line input is fanned out to both switch outputs, and each of those two copies has its own enable. Every output is modelled as a data bit plus a drive flag, because high impedance cannot exist inside the chip. A driven output carries its data bit. An undriven output reads as zero.

All six output enables together set a device-wide power state. When every enable is low, the block drops into powerdown and its internal reference is lost. The first enable to go high starts a shared reference ramp of `T_WAKE` cycles. An output that is enabled while the reference is already up becomes valid after its own `T_ON` cycles. Dropping an enable takes that output off its drive on the next edge. An enable that drops before its count ends cancels the count.

Top module: `xpt_link_ctrl`

## Requirements
- R1: While a line output is driven, `ln_out[c]` equals `sw_a_in[c]` when `sel[c]` is 1 and `sw_b_in[c]` when `sel[c]` is 0.
- R2: While a line output is not driven, `ln_out[c]` and `ln_pe[c]` read 0 whatever the select, data and pre-emphasis inputs are.
- R3: While a switch-side output is driven, `sa_out[c]` and `sb_out[c]` equal `ln_in[c]`. The two switch-side enables of a channel act independently, so zero, one or both copies may be driven.
- R4: Each driven output reports its pre-emphasis input bit unchanged on its `*_pe` pin (0 = off, 1 = full). An undriven output reports 0.
- R5: Disabling any one output leaves the other outputs driven. While at least one enable is high, `pwr_dn` stays 0.
- R6: After an edge at which all six enables are sampled low, `pwr_dn` is 1, `ref_ok` is 0 and no output is driven.
- R7: An enable sampled high while in powerdown clears `pwr_dn` at that edge. `ref_ok` rises at the `T_WAKE`-th consecutive edge with any enable high. Every output whose enable is high at that edge becomes driven at that same edge. If all enables drop during the ramp, the ramp restarts from zero.
- R8: An output enabled while `ref_ok` is 1 becomes driven at the `T_ON`-th consecutive edge at which its enable is sampled high.
- R9: An enable sampled low makes its output undriven after that same edge.
- R10: If an enable drops before its turn-on count ends, the drive flag never pulses high, and a later enable waits the full count again.
- R11: A synchronous reset (`rst` high at an edge) puts the block into powerdown with `ref_ok` 0 and all outputs undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | NCH | Per-channel line source select: 1 picks A, 0 picks B |
| sw_a_in | input | NCH | Switch-side A data inputs |
| sw_b_in | input | NCH | Switch-side B data inputs |
| ln_in | input | NCH | Line-side data inputs |
| en_ln | input | NCH | Line output enables |
| en_sa | input | NCH | Switch A output enables |
| en_sb | input | NCH | Switch B output enables |
| pe_ln | input | NCH | Line output pre-emphasis bits |
| pe_sa | input | NCH | Switch A output pre-emphasis bits |
| pe_sb | input | NCH | Switch B output pre-emphasis bits |
| ln_out | output | NCH | Line output data |
| ln_drv | output | NCH | Line output drive flag |
| ln_pe | output | NCH | Line output pre-emphasis status |
| sa_out | output | NCH | Switch A output data |
| sa_drv | output | NCH | Switch A output drive flag |
| sa_pe | output | NCH | Switch A pre-emphasis status |
| sb_out | output | NCH | Switch B output data |
| sb_drv | output | NCH | Switch B output drive flag |
| sb_pe | output | NCH | Switch B pre-emphasis status |
| pwr_dn | output | 1 | Device is in powerdown |
| ref_ok | output | 1 | Internal reference is ready |

## Verification
The bench measures the turn-on latency in edges in several situations: a wake from powerdown, an enable while the reference is up, an output that joins a wake that is already under way, and a wake that is aborted and then restarted. A design that confused the two latencies, or that gave the late joiner its own full ramp, would report the wrong edge count. Enables are dropped one edge before their count would end, to catch a drive flag that glitches or a counter that resumes instead of restarting. The bench sweeps every select, data and pre-emphasis pattern on both channels, and every pair of switch-side enables, to catch swapped mux legs, coupled enables or a stray powerdown while one output is still on.

// File: rtl/xpt_link_ctrl.sv
module xpt_link_ctrl #(
  parameter int NCH    = 2,
  parameter int T_ON   = 6,
  parameter int T_WAKE = 25
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] sel,
  input  logic [NCH-1:0] sw_a_in,
  input  logic [NCH-1:0] sw_b_in,
  input  logic [NCH-1:0] ln_in,
  input  logic [NCH-1:0] en_ln,
  input  logic [NCH-1:0] en_sa,
  input  logic [NCH-1:0] en_sb,
  input  logic [NCH-1:0] pe_ln,
  input  logic [NCH-1:0] pe_sa,
  input  logic [NCH-1:0] pe_sb,
  output logic [NCH-1:0] ln_out,
  output logic [NCH-1:0] ln_drv,
  output logic [NCH-1:0] ln_pe,
  output logic [NCH-1:0] sa_out,
  output logic [NCH-1:0] sa_drv,
  output logic [NCH-1:0] sa_pe,
  output logic [NCH-1:0] sb_out,
  output logic [NCH-1:0] sb_drv,
  output logic [NCH-1:0] sb_pe,
  output logic           pwr_dn,
  output logic           ref_ok
);
  localparam int NOUT = 3 * NCH;
  localparam int CW_ON = $clog2(T_ON + 1);
  localparam int CW_WK = $clog2(T_WAKE + 1);
  localparam logic [CW_ON-1:0] ON_LAST = CW_ON'(T_ON - 1);
  localparam logic [CW_WK-1:0] WK_LAST = CW_WK'(T_WAKE - 1);

  logic [NOUT-1:0]  en_v;
  logic [NOUT-1:0]  drv_v;
  logic [CW_WK-1:0] wcnt;
  logic             any_en;
  logic             wake_done;

  assign en_v      = {en_sb, en_sa, en_ln};
  assign any_en    = |en_v;
  assign wake_done = any_en && !ref_ok && (wcnt == WK_LAST);

  always_ff @(posedge clk) begin
    if (rst) pwr_dn <= 1'b1;
    else     pwr_dn <= !any_en;
  end

  always_ff @(posedge clk) begin
    if (rst || !any_en) begin
      wcnt   <= '0;
      ref_ok <= 1'b0;
    end else if (!ref_ok) begin
      if (wcnt == WK_LAST) ref_ok <= 1'b1;
      else                 wcnt   <= wcnt + 1'b1;
    end
  end

  for (genvar k = 0; k < NOUT; k++) begin : g_out
    logic [CW_ON-1:0] cnt;
    logic             vld;
    always_ff @(posedge clk) begin
      if (rst || !en_v[k]) begin
        cnt <= '0;
        vld <= 1'b0;
      end else if (!vld) begin
        if (!ref_ok) begin
          cnt <= '0;
          vld <= wake_done;
        end else if (cnt == ON_LAST) begin
          vld <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
    assign drv_v[k] = vld;
  end

  assign ln_drv = drv_v[NCH-1:0];
  assign sa_drv = drv_v[2*NCH-1:NCH];
  assign sb_drv = drv_v[3*NCH-1:2*NCH];

  assign ln_out = ln_drv & ((sel & sw_a_in) | (~sel & sw_b_in));
  assign sa_out = sa_drv & ln_in;
  assign sb_out = sb_drv & ln_in;
  assign ln_pe  = ln_drv & pe_ln;
  assign sa_pe  = sa_drv & pe_sa;
  assign sb_pe  = sb_drv & pe_sb;
endmodule

module xpt_link_ctrl_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] sel,
  input logic [NCH-1:0] sw_a_in,
  input logic [NCH-1:0] sw_b_in,
  input logic [NCH-1:0] ln_in,
  input logic [NCH-1:0] en_ln,
  input logic [NCH-1:0] en_sa,
  input logic [NCH-1:0] en_sb,
  input logic [NCH-1:0] pe_ln,
  input logic [NCH-1:0] pe_sa,
  input logic [NCH-1:0] pe_sb,
  input logic [NCH-1:0] ln_out,
  input logic [NCH-1:0] ln_drv,
  input logic [NCH-1:0] ln_pe,
  input logic [NCH-1:0] sa_out,
  input logic [NCH-1:0] sa_drv,
  input logic [NCH-1:0] sa_pe,
  input logic [NCH-1:0] sb_out,
  input logic [NCH-1:0] sb_drv,
  input logic [NCH-1:0] sb_pe,
  input logic           pwr_dn,
  input logic           ref_ok
);
  logic [3*NCH-1:0] c_en;
  logic [3*NCH-1:0] c_drv;
  assign c_en  = {en_sb, en_sa, en_ln};
  assign c_drv = {sb_drv, sa_drv, ln_drv};

  a_r6_pd_quiet: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |-> (c_drv == '0 && !ref_ok));

  for (genvar k = 0; k < 3*NCH; k++) begin : g_k
    a_r9_drv_needs_en: assert property (@(posedge clk) disable iff (rst)
      c_drv[k] |-> $past(c_en[k]));
    a_r7_rise_needs_ref: assert property (@(posedge clk) disable iff (rst)
      $rose(c_drv[k]) |-> ref_ok);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_c
    a_r1_line_mux: assert property (@(posedge clk) disable iff (rst)
      ln_drv[c] |-> ln_out[c] == (sel[c] ? sw_a_in[c] : sw_b_in[c]));
    a_r3_fanout: assert property (@(posedge clk) disable iff (rst)
      (sa_drv[c] |-> sa_out[c] == ln_in[c]) and (sb_drv[c] |-> sb_out[c] == ln_in[c]));
    a_r2_undriven_zero: assert property (@(posedge clk) disable iff (rst)
      !ln_drv[c] |-> (!ln_out[c] && !ln_pe[c]));
  end
endmodule

bind xpt_link_ctrl xpt_link_ctrl_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/test_xpt_link_ctrl.sv
module test_xpt_link_ctrl;
  localparam int NCH = 2;
  localparam int TON = 3;
  localparam int TWK = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] sel = '0, sw_a_in = '0, sw_b_in = '0, ln_in = '0;
  logic [NCH-1:0] en_ln = '0, en_sa = '0, en_sb = '0;
  logic [NCH-1:0] pe_ln = '0, pe_sa = '0, pe_sb = '0;
  logic [NCH-1:0] ln_out, ln_drv, ln_pe, sa_out, sa_drv, sa_pe, sb_out, sb_drv, sb_pe;
  logic pwr_dn, ref_ok;
  logic [3*NCH-1:0] drv_all;
  int n_chk = 0, n_fail = 0;

  assign drv_all = {sb_drv, sa_drv, ln_drv};

  always #10 clk = ~clk;

  xpt_link_ctrl #(.NCH(NCH), .T_ON(TON), .T_WAKE(TWK)) i_xpt_link_ctrl (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_drv(input int idx, output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      step();
      n++;
      if (drv_all[idx]) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    step(); step(); step();
    rst = 1'b0;
    step();
    check("R11 reset pwr_dn", pwr_dn, 1);
    check("R11 reset drv", drv_all, 0);
    check("R11 reset ref_ok", ref_ok, 0);

    en_ln[0] = 1'b1;
    wait_drv(0, n);
    check("R7 wake latency", n, TWK);
    check("R7 ref_ok up", ref_ok, 1);
    check("R7 pwr_dn low", pwr_dn, 0);

    en_sa[1] = 1'b1;
    wait_drv(NCH + 1, n);
    check("R8 tristate latency", n, TON);
    check("R5 line0 still driven", ln_drv[0], 1);

    en_ln = '1; en_sa = '1; en_sb = '1;
    repeat (TON + 1) step();
    check("R8 all driven", drv_all, (1 << 3*NCH) - 1);
    for (int v = 0; v < 256; v++) begin
      sel = v[1:0]; sw_a_in = v[3:2]; sw_b_in = v[5:4]; ln_in = v[7:6];
      pe_ln = v[1:0] ^ v[7:6]; pe_sa = v[3:2] ^ v[1:0]; pe_sb = ~v[5:4];
      #1;
      for (int c = 0; c < NCH; c++) begin
        check("R1 line mux", ln_out[c], sel[c] ? sw_a_in[c] : sw_b_in[c]);
        check("R3 fanout A", sa_out[c], ln_in[c]);
        check("R3 fanout B", sb_out[c], ln_in[c]);
        check("R4 pe", {ln_pe[c], sa_pe[c], sb_pe[c]}, {pe_ln[c], pe_sa[c], pe_sb[c]});
      end
      step();
    end

    for (int c = 0; c < NCH; c++) begin
      for (int m = 0; m < 4; m++) begin
        en_sa[c] = m[0]; en_sb[c] = m[1];
        repeat (TON + 1) step();
        check("R3 independent A", sa_drv[c], m[0]);
        check("R3 independent B", sb_drv[c], m[1]);
        check("R5 lines kept", ln_drv, (1 << NCH) - 1);
        check("R5 no powerdown", pwr_dn, 0);
        check("R4 pe off when undriven", sa_pe[c] | sb_pe[c], (m[0] & pe_sa[c]) | (m[1] & pe_sb[c]));
      end
      en_sa[c] = 1'b1; en_sb[c] = 1'b1;
      repeat (TON + 1) step();
    end

    en_ln[1] = 1'b0;
    step();
    check("R9 turn-off one edge", ln_drv[1], 0);
    for (int v = 0; v < 16; v++) begin
      sel[1] = v[0]; sw_a_in[1] = v[1]; sw_b_in[1] = v[2]; pe_ln[1] = v[3];
      #1;
      check("R2 undriven data", ln_out[1], 0);
      check("R2 undriven pe", ln_pe[1], 0);
      step();
    end

    en_ln[1] = 1'b1;
    for (int i = 0; i < TON - 1; i++) begin
      step();
      check("R10 no early drive", ln_drv[1], 0);
    end
    en_ln[1] = 1'b0;
    step();
    check("R10 cancelled", ln_drv[1], 0);
    step();
    check("R10 stays off", ln_drv[1], 0);
    en_ln[1] = 1'b1;
    wait_drv(1, n);
    check("R10 full restart", n, TON);

    en_ln = '0; en_sa = '0; en_sb = '0;
    step();
    check("R6 pwr_dn", pwr_dn, 1);
    check("R6 ref lost", ref_ok, 0);
    check("R9 R6 all off", drv_all, 0);

    en_ln[0] = 1'b1;
    repeat (3) step();
    check("R7 not yet valid", ln_drv[0], 0);
    en_sb[1] = 1'b1;
    wait_drv(2*NCH + 1, n);
    check("R7 shared wake joiner", n, TWK - 3);
    check("R7 shared wake first", ln_drv[0], 1);

    en_ln = '0; en_sb = '0;
    step();
    en_sa[0] = 1'b1;
    repeat (4) step();
    en_sa[0] = 1'b0;
    step();
    check("R7 abort to powerdown", pwr_dn, 1);
    en_sa[0] = 1'b1;
    wait_drv(NCH, n);
    check("R7 ramp restarts", n, TWK);

    rst = 1'b1;
    step();
    check("R11 mid reset pwr_dn", pwr_dn, 1);
    check("R11 mid reset drv", drv_all, 0);
    check("R11 mid reset ref", ref_ok, 0);
    rst = 1'b0;
    step();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule